// File: doc/BRIEF.md
# Decoder Bring-Up and Playback Sequencer

This block drives the register-write side of a serial control bus for an audio decoder. Once reset is released it holds the decoder's reset line active for a fixed number of clocks. It then reads a long table of register address/value pairs from an external synchronous ROM and turns each pair into one register write. A short table of board-specific writes follows, taken from a parameter. A final write switches the decoder into its running state, and the block then goes idle.

In the idle state the block watches two push buttons. It samples them on a slow periodic tick and debounces each one. A clean press of the first button writes the start-playback value to the decoder's play register. A clean press of the second button writes the stop value to the same register. All writes go through a single request port. Each one waits until the bus master downstream reports that the previous write has finished, so at most one write is in flight at any time.

Top module: `cfg_play_ctrl`

## Requirements
- R1: While `rst` is high, `dec_reset` is 1 and `wr_req` is 0.
- R2: After `rst` falls, `dec_reset` stays 1 through the first RST_CYCLES rising clock edges (default 16, never fewer than 16) and then drops to 0. No write is requested while `dec_reset` is 1.
- R3: The first ROM_LEN writes follow ROM entries 0 to ROM_LEN-1 in order. An entry is read one clock after its index is presented on `rom_addr`. Bits [15:8] of the entry are the register address and bits [7:0] are the value.
- R4: The next BOARD_LEN writes follow the parameter table in order. Entry k occupies bits [16k+15:16k] of BOARD_TABLE and uses the same address/value split as R3.
- R5: The write after the board table puts value 0x01 to register 0x72. This completes bring-up.
- R6: `wr_req` is a one-cycle pulse. No new pulse is issued until `wr_done` has been seen for the previous write.
- R7: The buttons are sampled once every TICK_CYCLES clocks. A press counts only after two consecutive samples read pressed, so a press seen by a single sample produces no write.
- R8: Each press produces exactly one write, however long the button is held. The button re-arms only after two consecutive samples read released.
- R9: A press on `btn_raw[0]` writes value 0x01 to register 0x13.
- R10: A press on `btn_raw[1]` writes value 0x00 to register 0x13.
- R11: Button activity before the R5 write completes produces no write, either then or later.
- R12: A press detected while a write is in flight is kept pending and issued once the port is free. When both buttons are pending, the `btn_raw[0]` write goes first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 2 | Asynchronous button levels, 1 = pressed; bit 0 starts playback, bit 1 stops it |
| rom_addr | output | ROM_AW | Index into the configuration ROM |
| rom_data | input | 16 | ROM entry, one clock after `rom_addr` |
| dec_reset | output | 1 | Active-high reset to the decoder |
| wr_req | output | 1 | One-cycle register-write request |
| wr_addr | output | 8 | Register address of the request |
| wr_data | output | 8 | Register value of the request |
| wr_done | input | 1 | Pulse from the bus master when the current write has finished |

## Verification
The bench builds the block with a 12-entry ROM, a 3-entry board table and an 8-clock sampling tick, and keeps the 16-clock reset hold. The ROM model returns an arithmetic function of the index, so every bring-up write can be compared against a computed value. With the tick this short, single-sample glitches, single-sample dips during a held press, long holds and simultaneous presses all fit in a few hundred cycles. The bus master model varies its completion delay from write to write, so the pending-press path and the one-in-flight rule are exercised under several timings.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
  } regwr_t;

  typedef enum logic [2:0] {
    B_RESET,
    B_FETCH,
    B_LOAD,
    B_WAIT,
    B_IDLE
  } boot_st_t;

  typedef enum logic [1:0] {
    P_ROM,
    P_BOARD,
    P_RUN
  } phase_t;

  typedef enum logic {
    D_ARMED,
    D_HELD
  } deb_st_t;

  localparam logic [7:0] RUN_REG   = 8'h72;
  localparam logic [7:0] RUN_ON    = 8'h01;
  localparam logic [7:0] PLAY_REG  = 8'h13;
  localparam logic [7:0] PLAY_GO   = 8'h01;
  localparam logic [7:0] PLAY_HALT = 8'h00;

endpackage

// File: rtl/cfg_debounce.sv
module cfg_debounce
  import cfg_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic enable,
  input  logic raw,
  output logic press
);

  logic    sync1, sync2;
  logic    hit;
  deb_st_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= raw;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= D_ARMED;
      hit   <= 1'b0;
      press <= 1'b0;
    end else begin
      press <= 1'b0;
      if (!enable) begin
        st  <= D_ARMED;
        hit <= 1'b0;
      end else if (tick) begin
        case (st)
          D_ARMED: begin
            if (sync2) begin
              if (hit) begin
                press <= 1'b1;
                st    <= D_HELD;
                hit   <= 1'b0;
              end else begin
                hit <= 1'b1;
              end
            end else begin
              hit <= 1'b0;
            end
          end
          default: begin
            if (!sync2) begin
              if (hit) begin
                st  <= D_ARMED;
                hit <= 1'b0;
              end else begin
                hit <= 1'b1;
              end
            end else begin
              hit <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  // R11: nothing is reported while disabled
  a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !press);

  // R8: one pulse per press
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    press |=> !press);

endmodule

// File: rtl/cfg_boot.sv
module cfg_boot
  import cfg_seq_pkg::*;
#(
  parameter int ROM_LEN    = 2007,
  parameter int BOARD_LEN  = 4,
  parameter logic [BOARD_LEN*16-1:0] BOARD_TABLE = {16'h5402, 16'h5180, 16'h0C10, 16'h5510},
  parameter int RST_CYCLES = 16,
  localparam int ROM_AW = (ROM_LEN > 1) ? $clog2(ROM_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_done,
  input  logic [15:0]       rom_data,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              dec_reset,
  output logic              req,
  output regwr_t            req_wr,
  output logic              idle
);

  localparam int MAXLEN = (ROM_LEN > BOARD_LEN) ? ROM_LEN : BOARD_LEN;
  localparam int IDX_W  = $clog2(MAXLEN + 1);
  localparam int RC_W   = $clog2(RST_CYCLES + 1);
  localparam logic [IDX_W-1:0] ROM_LAST   = IDX_W'(ROM_LEN - 1);
  localparam logic [IDX_W-1:0] BOARD_LAST = IDX_W'(BOARD_LEN - 1);
  localparam logic [RC_W-1:0]  RC_LAST    = RC_W'(RST_CYCLES);

  boot_st_t         st;
  phase_t           phase;
  logic [IDX_W-1:0] idx;
  logic [RC_W-1:0]  rcnt;
  regwr_t           board_ent;

  assign rom_addr  = idx[ROM_AW-1:0];
  assign board_ent = regwr_t'(BOARD_TABLE[idx*16 +: 16]);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= B_RESET;
      phase     <= P_ROM;
      idx       <= '0;
      rcnt      <= '0;
      dec_reset <= 1'b1;
      req       <= 1'b0;
      req_wr    <= '0;
      idle      <= 1'b0;
    end else begin
      req <= 1'b0;
      case (st)
        B_RESET: begin
          if (rcnt == RC_LAST) begin
            dec_reset <= 1'b0;
            st        <= B_FETCH;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        B_FETCH: st <= B_LOAD;
        B_LOAD: begin
          case (phase)
            P_ROM:   req_wr <= regwr_t'(rom_data);
            P_BOARD: req_wr <= board_ent;
            default: req_wr <= '{addr: RUN_REG, data: RUN_ON};
          endcase
          req <= 1'b1;
          st  <= B_WAIT;
        end
        B_WAIT: begin
          if (wr_done) begin
            st <= B_FETCH;
            case (phase)
              P_ROM: begin
                if (idx == ROM_LAST) begin
                  phase <= P_BOARD;
                  idx   <= '0;
                end else begin
                  idx <= idx + 1'b1;
                end
              end
              P_BOARD: begin
                if (idx == BOARD_LAST) begin
                  phase <= P_RUN;
                  idx   <= '0;
                end else begin
                  idx <= idx + 1'b1;
                end
              end
              default: begin
                st   <= B_IDLE;
                idle <= 1'b1;
              end
            endcase
          end
        end
        default: idle <= 1'b1;
      endcase
    end
  end

  // R2: no write while the decoder is held in reset
  a_r2_quiet_in_reset: assert property (@(posedge clk) disable iff (rst)
    dec_reset |-> !req);

  // R5: bring-up ends only after the run phase
  a_r5_run_last: assert property (@(posedge clk) disable iff (rst)
    $rose(idle) |-> $past(phase == P_RUN));

  // R3: a ROM write is requested only after a load step
  a_r3_load_before_req: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> $past(st == B_LOAD));

endmodule

// File: rtl/cfg_play_ctrl.sv
module cfg_play_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int TICK_CYCLES = 10_000_000,
  parameter int ROM_LEN     = 2007,
  parameter int BOARD_LEN   = 4,
  parameter logic [BOARD_LEN*16-1:0] BOARD_TABLE = {16'h5402, 16'h5180, 16'h0C10, 16'h5510},
  parameter int RST_CYCLES  = 16,
  localparam int ROM_AW = (ROM_LEN > 1) ? $clog2(ROM_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        btn_raw,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [15:0]       rom_data,
  output logic              dec_reset,
  output logic              wr_req,
  output logic [7:0]        wr_addr,
  output logic [7:0]        wr_data,
  input  logic              wr_done
);

  localparam int NBTN = 2;
  localparam int TW   = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CYCLES - 1);

  logic [TW-1:0]   tcnt;
  logic            tick;
  logic            boot_req, boot_idle;
  regwr_t          boot_wr;
  logic [NBTN-1:0] press, pend, sel;
  logic            busy, can_issue;

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (tcnt == TICK_LAST);
      tcnt <= (tcnt == TICK_LAST) ? '0 : tcnt + 1'b1;
    end
  end

  cfg_boot #(
    .ROM_LEN     (ROM_LEN),
    .BOARD_LEN   (BOARD_LEN),
    .BOARD_TABLE (BOARD_TABLE),
    .RST_CYCLES  (RST_CYCLES)
  ) u_boot (
    .clk       (clk),
    .rst       (rst),
    .wr_done   (wr_done),
    .rom_data  (rom_data),
    .rom_addr  (rom_addr),
    .dec_reset (dec_reset),
    .req       (boot_req),
    .req_wr    (boot_wr),
    .idle      (boot_idle)
  );

  for (genvar i = 0; i < NBTN; i++) begin : g_btn
    cfg_debounce u_deb (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .enable (boot_idle),
      .raw    (btn_raw[i]),
      .press  (press[i])
    );
  end

  assign can_issue = boot_idle && !busy && !wr_req;
  assign sel[0]    = can_issue && pend[0];
  assign sel[1]    = can_issue && !pend[0] && pend[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= '0;
      busy    <= 1'b0;
      wr_req  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      pend <= (pend & ~sel) | press;
      if (wr_done) busy <= 1'b0;
      if (wr_req)  busy <= 1'b1;
      wr_req <= 1'b0;
      if (boot_req) begin
        wr_req  <= 1'b1;
        wr_addr <= boot_wr.addr;
        wr_data <= boot_wr.data;
      end else if (sel[0]) begin
        wr_req  <= 1'b1;
        wr_addr <= PLAY_REG;
        wr_data <= PLAY_GO;
      end else if (sel[1]) begin
        wr_req  <= 1'b1;
        wr_addr <= PLAY_REG;
        wr_data <= PLAY_HALT;
      end
    end
  end

  // R6: never a second request while one is in flight
  a_r6_single_outstanding: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> !busy);

  // R6: requests are single-cycle pulses
  a_r6_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> !wr_req);

  // R11: no press can be queued before bring-up is complete
  a_r11_no_pending_early: assert property (@(posedge clk) disable iff (rst)
    !boot_idle |-> (pend == '0));

  // R7: sampling ticks are isolated pulses
  a_r7_tick_gap: assert property (@(posedge clk) disable iff (rst)
    (tick && (TICK_CYCLES > 1)) |=> !tick);

  // R1: reset values
  always @(posedge clk) begin
    if (rst) a_r1_reset_quiet: assert (!wr_req || $past(rst) == 1'b0);
  end

endmodule

// File: tb/cfg_play_ctrl_test.sv
module cfg_play_ctrl_test;

  localparam int TICK   = 8;
  localparam int RLEN   = 12;
  localparam int BLEN   = 3;
  localparam int RSTC   = 16;
  localparam logic [BLEN*16-1:0] BTAB = {16'hA03E, 16'h1907, 16'hC244};
  localparam int NBOOT  = RLEN + BLEN + 1;
  localparam int AW     = $clog2(RLEN);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    btn_raw = 2'b00;
  logic [AW-1:0] rom_addr;
  logic [15:0]   rom_data = '0;
  logic          dec_reset, wr_req, wr_done = 1'b0;
  logic [7:0]    wr_addr, wr_data;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [7:0] log_a [0:63];
  logic [7:0] log_d [0:63];
  int n_log = 0;
  bit outstanding = 0;
  int dly = 0;

  always #2.5 clk = ~clk;

  cfg_play_ctrl #(
    .TICK_CYCLES (TICK),
    .ROM_LEN     (RLEN),
    .BOARD_LEN   (BLEN),
    .BOARD_TABLE (BTAB),
    .RST_CYCLES  (RSTC)
  ) uut (
    .clk       (clk),
    .rst       (rst),
    .btn_raw   (btn_raw),
    .rom_addr  (rom_addr),
    .rom_data  (rom_data),
    .dec_reset (dec_reset),
    .wr_req    (wr_req),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_done   (wr_done)
  );

  function automatic logic [15:0] rom_fn(int i);
    logic [7:0] a, d;
    a = 8'(i * 5 + 1);
    d = 8'(i * 3) ^ 8'h5A;
    return {a, d};
  endfunction

  // synchronous ROM model, one clock of latency
  always @(posedge clk) rom_data <= rom_fn(int'(rom_addr));

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // bus master model: logs requests, answers with a varying delay
  always @(negedge clk) begin
    if (rst) begin
      outstanding = 0;
      wr_done = 1'b0;
    end else begin
      if (wr_done) begin
        wr_done = 1'b0;
        outstanding = 0;
      end else if (outstanding) begin
        if (dly == 0) wr_done = 1'b1;
        else dly--;
      end
      if (wr_req) begin
        chk(!outstanding, "R6 request while busy", 1, 0);
        if (n_log < 64) begin
          log_a[n_log] = wr_addr;
          log_d[n_log] = wr_data;
        end
        n_log++;
        outstanding = 1;
        dly = 1 + (n_log % 4);
      end
    end
  end

  task automatic wait_ticks(int n);
    repeat (n * TICK) @(negedge clk);
  endtask

  task automatic chk_entry(int k, logic [7:0] ea, logic [7:0] ed, string req);
    chk(log_a[k] == ea, req, int'(log_a[k]), int'(ea));
    chk(log_d[k] == ed, req, int'(log_d[k]), int'(ed));
  endtask

  initial begin
    int hold;
    int base;
    repeat (4) @(negedge clk);
    chk(dec_reset == 1'b1, "R1 dec_reset in reset", int'(dec_reset), 1);
    chk(wr_req == 1'b0, "R1 wr_req in reset", int'(wr_req), 0);
    // R11: press held during bring-up, released before it ends
    btn_raw[0] = 1'b1;
    rst = 1'b0;
    hold = 0;
    @(negedge clk);
    while (dec_reset) begin
      hold++;
      @(negedge clk);
    end
    chk(hold == RSTC, "R2 reset hold cycles", hold, RSTC);
    chk(n_log == 0, "R2 no write during reset", n_log, 0);
    repeat (20) @(negedge clk);
    btn_raw[0] = 1'b0;
    for (int w = 0; w < 2000 && n_log < NBOOT; w++) @(negedge clk);
    wait_ticks(8);
    chk(n_log == NBOOT, "R11 boot write count", n_log, NBOOT);
    for (int i = 0; i < RLEN; i++)
      chk_entry(i, rom_fn(i) >> 8, rom_fn(i) & 8'hFF, "R3 rom entry");
    for (int k = 0; k < BLEN; k++)
      chk_entry(RLEN + k, BTAB[k*16+8 +: 8], BTAB[k*16 +: 8], "R4 board entry");
    chk_entry(RLEN + BLEN, 8'h72, 8'h01, "R5 run write");

    // R7: single-sample glitch
    base = n_log;
    btn_raw[0] = 1'b1;
    repeat (TICK - 2) @(negedge clk);
    btn_raw[0] = 1'b0;
    wait_ticks(6);
    chk(n_log == base, "R7 glitch ignored", n_log, base);

    // R9 / R8: long hold gives one start write
    btn_raw[0] = 1'b1;
    wait_ticks(10);
    btn_raw[0] = 1'b0;
    wait_ticks(4);
    chk(n_log == base + 1, "R8 one write per hold", n_log, base + 1);
    chk_entry(base, 8'h13, 8'h01, "R9 play start");

    // R8: one-sample dip does not re-arm
    base = n_log;
    btn_raw[0] = 1'b1;
    wait_ticks(6);
    btn_raw[0] = 1'b0;
    repeat (TICK - 2) @(negedge clk);
    btn_raw[0] = 1'b1;
    wait_ticks(6);
    btn_raw[0] = 1'b0;
    wait_ticks(4);
    chk(n_log == base + 1, "R8 dip not re-armed", n_log, base + 1);

    // R10: stop button
    base = n_log;
    btn_raw[1] = 1'b1;
    wait_ticks(5);
    btn_raw[1] = 1'b0;
    wait_ticks(4);
    chk(n_log == base + 1, "R10 stop count", n_log, base + 1);
    chk_entry(base, 8'h13, 8'h00, "R10 play stop");

    // R12: simultaneous presses, start first then stop
    for (int rep = 0; rep < 3; rep++) begin
      base = n_log;
      btn_raw = 2'b11;
      wait_ticks(5 + rep);
      btn_raw = 2'b00;
      wait_ticks(4);
      chk(n_log == base + 2, "R12 both issued", n_log, base + 2);
      chk_entry(base, 8'h13, 8'h01, "R12 start first");
      chk_entry(base + 1, 8'h13, 8'h00, "R12 stop second");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule